// File: doc/BRIEF.md
# Streaming Mode Control Unit

This block keeps the two mode bits of a vector core: one that turns streaming execution on and one that turns the matrix storage on. A command port updates these bits. A write sets one bit to a given value. A start or stop command sets or clears whichever bits it selects. When the streaming bit actually flips, in either direction, the block raises a one-cycle clear pulse to the vector register file and to the predicate register file. When the matrix-storage bit goes from 0 to 1, it raises a one-cycle clear pulse to the matrix storage.

The block also turns a small length-control code into the effective streaming vector length in bytes. It answers a length query with that byte count multiplied by a signed immediate, one cycle after the query is issued. The query result always uses the streaming length, even while streaming execution is off.

Top module: `stream_mode_ctl`

## Requirements
- R1: After reset, `strm_en`, `mtx_en`, `vreg_clr`, `preg_clr`, `mtx_clr` and `q_rvalid` are all 0.
- R2: A command with `cmd_valid`=1 and `cmd_op`=1 loads `cmd_wdata` into `strm_en` on the next clock edge and leaves `mtx_en` unchanged.
- R3: A command with `cmd_op`=2 loads `cmd_wdata` into `mtx_en` on the next clock edge and leaves `strm_en` unchanged.
- R4: `cmd_op`=3 (start) sets each bit whose select input (`cmd_sel_strm`, `cmd_sel_mtx`) is 1. `cmd_op`=4 (stop) clears each selected bit. Bits that are not selected keep their value.
- R5: When `strm_en` changes value, `vreg_clr` and `preg_clr` are 1 for exactly the first cycle that shows the new value.
- R6: A command that leaves `strm_en` at its current value, including a write of the same value, raises neither `vreg_clr` nor `preg_clr`.
- R7: `mtx_clr` is 1 for exactly the first cycle after `mtx_en` rises from 0 to 1. It is never raised on a fall or on a command that leaves `mtx_en` unchanged.
- R8: `svl_bytes` equals 16 << `len_ctl` for `len_ctl` codes 0 to 4, which gives 16, 32, 64, 128 and 256 bytes.
- R9: Any `len_ctl` code above 4 is clamped, so `svl_bytes` is 256.
- R10: A query with `q_valid`=1 gives `q_rvalid`=1 on the next cycle. In that cycle `q_result` is the 64-bit two's-complement product of `svl_bytes` and the 6-bit signed `q_imm` (-32 to 31). The product does not depend on `strm_en`. `q_rvalid` is 0 in the cycle after a cycle without a query.
- R11: Commands with `cmd_valid`=0, or with `cmd_op` equal to 0, 5, 6 or 7, change no mode bit and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 write streaming bit, 2 write matrix bit, 3 start, 4 stop |
| cmd_sel_strm | input | 1 | Start/stop acts on the streaming bit |
| cmd_sel_mtx | input | 1 | Start/stop acts on the matrix-storage bit |
| cmd_wdata | input | 1 | Value for the write commands |
| len_ctl | input | 3 | Length code, log2 of bytes/16 |
| q_valid | input | 1 | Length query present |
| q_imm | input | 6 | Signed multiplier for the query |
| strm_en | output | 1 | Streaming mode bit |
| mtx_en | output | 1 | Matrix-storage enable bit |
| vreg_clr | output | 1 | Clear pulse to the vector register file |
| preg_clr | output | 1 | Clear pulse to the predicate register file |
| mtx_clr | output | 1 | Clear pulse to the matrix storage |
| svl_bytes | output | 9 | Effective streaming length in bytes |
| q_rvalid | output | 1 | Query result valid |
| q_result | output | 64 | Signed query product |

## Verification
The assertions check on every cycle that the register-file clear coincides exactly with a flip of the streaming bit. They also check that the matrix clear appears only on a rising matrix bit, that idle cycles hold both bits, that the length output is a clamped power of two, and that query validity follows one cycle after the request. Only the bench scenarios can show that each command and select combination, applied to every starting state, lands on the right bit values. The same holds for the correct product value across every length code and every immediate, in both streaming states.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_WR_STRM = 3'd1,
        OP_WR_MTX  = 3'd2,
        OP_START   = 3'd3,
        OP_STOP    = 3'd4
    } smc_op_e;
endpackage

// File: rtl/smc_len_decode.sv
`timescale 1ns/1ps
module smc_len_decode #(
    parameter int LEN_CTL_W  = 3,
    parameter int MAX_LOG    = 4,
    parameter int BASE_BYTES = 16,
    parameter int BYTES_W    = 9
) (
    input  logic [LEN_CTL_W-1:0] len_ctl,
    output logic [BYTES_W-1:0]   bytes
);
    localparam int CODE_MAX = (1 << LEN_CTL_W) - 1;

    logic [LEN_CTL_W-1:0] eff_code;

    generate
        if (CODE_MAX > MAX_LOG) begin : g_clamp
            always_comb begin
                if (len_ctl > LEN_CTL_W'(MAX_LOG)) eff_code = LEN_CTL_W'(MAX_LOG);
                else                               eff_code = len_ctl;
            end
        end else begin : g_pass
            always_comb eff_code = len_ctl;
        end
    endgenerate

    always_comb bytes = BYTES_W'(BASE_BYTES) << eff_code;
endmodule

// File: rtl/smc_len_query.sv
`timescale 1ns/1ps
module smc_len_query #(
    parameter int BYTES_W = 9,
    parameter int IMM_W   = 6,
    parameter int RES_W   = 64
) (
    input  logic [BYTES_W-1:0]      bytes,
    input  logic signed [IMM_W-1:0] imm,
    output logic [RES_W-1:0]        prod
);
    localparam int PW = BYTES_W + 1 + IMM_W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] p;

    always_comb begin
        a_ext = PW'(signed'({1'b0, bytes}));
        b_ext = PW'(imm);
        p     = a_ext * b_ext;
        prod  = {{(RES_W-PW){p[PW-1]}}, p};
    end
endmodule

// File: rtl/stream_mode_ctl.sv
`timescale 1ns/1ps
module stream_mode_ctl #(
    parameter int LEN_CTL_W  = 3,
    parameter int MAX_LOG    = 4,
    parameter int BASE_BYTES = 16,
    parameter int IMM_W      = 6,
    parameter int RES_W      = 64,
    localparam int BYTES_W   = $clog2(BASE_BYTES << MAX_LOG) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic                 cmd_sel_strm,
    input  logic                 cmd_sel_mtx,
    input  logic                 cmd_wdata,
    input  logic [LEN_CTL_W-1:0] len_ctl,
    input  logic                 q_valid,
    input  logic [IMM_W-1:0]     q_imm,
    output logic                 strm_en,
    output logic                 mtx_en,
    output logic                 vreg_clr,
    output logic                 preg_clr,
    output logic                 mtx_clr,
    output logic [BYTES_W-1:0]   svl_bytes,
    output logic                 q_rvalid,
    output logic [RES_W-1:0]     q_result
);
    import smc_pkg::*;

    typedef struct packed {
        logic             strm;
        logic             mtx;
        logic             vclr;
        logic             mclr;
        logic             rvld;
        logic [RES_W-1:0] res;
    } smc_state_t;

    smc_state_t       st_d, st_q;
    logic [RES_W-1:0] prod;
    smc_op_e          op;

    smc_len_decode #(
        .LEN_CTL_W (LEN_CTL_W),
        .MAX_LOG   (MAX_LOG),
        .BASE_BYTES(BASE_BYTES),
        .BYTES_W   (BYTES_W)
    ) u_len_decode (
        .len_ctl(len_ctl),
        .bytes  (svl_bytes)
    );

    smc_len_query #(
        .BYTES_W(BYTES_W),
        .IMM_W  (IMM_W),
        .RES_W  (RES_W)
    ) u_len_query (
        .bytes(svl_bytes),
        .imm  ($signed(q_imm)),
        .prod (prod)
    );

    always_comb begin
        op      = smc_op_e'(cmd_op);
        st_d    = st_q;
        st_d.rvld = q_valid;
        if (q_valid) st_d.res = prod;
        if (cmd_valid) begin
            case (op)
                OP_WR_STRM: st_d.strm = cmd_wdata;
                OP_WR_MTX:  st_d.mtx  = cmd_wdata;
                OP_START: begin
                    if (cmd_sel_strm) st_d.strm = 1'b1;
                    if (cmd_sel_mtx)  st_d.mtx  = 1'b1;
                end
                OP_STOP: begin
                    if (cmd_sel_strm) st_d.strm = 1'b0;
                    if (cmd_sel_mtx)  st_d.mtx  = 1'b0;
                end
                default: ;
            endcase
        end
        st_d.vclr = st_d.strm ^ st_q.strm;
        st_d.mclr = st_d.mtx & ~st_q.mtx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strm_en  = st_q.strm;
    assign mtx_en   = st_q.mtx;
    assign vreg_clr = st_q.vclr;
    assign preg_clr = st_q.vclr;
    assign mtx_clr  = st_q.mclr;
    assign q_rvalid = st_q.rvld;
    assign q_result = st_q.res;
endmodule

// File: rtl/stream_mode_ctl_chk.sv
`timescale 1ns/1ps
module stream_mode_ctl_chk #(
    parameter int LEN_CTL_W = 3,
    parameter int MAX_LOG   = 4,
    parameter int BYTES_W   = 9,
    parameter int BASE_BYTES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [LEN_CTL_W-1:0] len_ctl,
    input logic                 q_valid,
    input logic                 strm_en,
    input logic                 mtx_en,
    input logic                 vreg_clr,
    input logic                 mtx_clr,
    input logic [BYTES_W-1:0]   svl_bytes,
    input logic                 q_rvalid
);
    localparam int TOP_BYTES = BASE_BYTES << MAX_LOG;

    assert_clr_on_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_en != $past(strm_en)) |-> vreg_clr);

    assert_no_idle_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_clr |-> (strm_en != $past(strm_en)));

    assert_mtx_clr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mtx_clr |-> (mtx_en && !$past(mtx_en)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(strm_en) && $stable(mtx_en)));

    assert_len_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(svl_bytes) == 1) && (svl_bytes >= BYTES_W'(BASE_BYTES))
        && (svl_bytes <= BYTES_W'(TOP_BYTES)));

    assert_len_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (len_ctl > LEN_CTL_W'(MAX_LOG)) |-> (svl_bytes == BYTES_W'(TOP_BYTES)));

    assert_query_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> q_rvalid);

    assert_query_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !q_rvalid);
endmodule

bind stream_mode_ctl stream_mode_ctl_chk #(
    .LEN_CTL_W (LEN_CTL_W),
    .MAX_LOG   (MAX_LOG),
    .BYTES_W   (BYTES_W),
    .BASE_BYTES(BASE_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .len_ctl  (len_ctl),
    .q_valid  (q_valid),
    .strm_en  (strm_en),
    .mtx_en   (mtx_en),
    .vreg_clr (vreg_clr),
    .mtx_clr  (mtx_clr),
    .svl_bytes(svl_bytes),
    .q_rvalid (q_rvalid)
);

// File: tb/stream_mode_ctl_bench.sv
`timescale 1ns/1ps
module stream_mode_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_sel_strm = 1'b0;
    logic        cmd_sel_mtx = 1'b0;
    logic        cmd_wdata = 1'b0;
    logic [2:0]  len_ctl = 3'd0;
    logic        q_valid = 1'b0;
    logic [5:0]  q_imm = 6'd0;
    logic        strm_en, mtx_en, vreg_clr, preg_clr, mtx_clr, q_rvalid;
    logic [8:0]  svl_bytes;
    logic [63:0] q_result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stream_mode_ctl u_stream_mode_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel_strm(cmd_sel_strm), .cmd_sel_mtx(cmd_sel_mtx), .cmd_wdata(cmd_wdata),
        .len_ctl(len_ctl), .q_valid(q_valid), .q_imm(q_imm),
        .strm_en(strm_en), .mtx_en(mtx_en), .vreg_clr(vreg_clr), .preg_clr(preg_clr),
        .mtx_clr(mtx_clr), .svl_bytes(svl_bytes), .q_rvalid(q_rvalid), .q_result(q_result)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input logic ss,
                         input logic sm, input logic wd);
        cmd_valid = v; cmd_op = op; cmd_sel_strm = ss; cmd_sel_mtx = sm; cmd_wdata = wd;
        tick();
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic es, em;
        string t;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 strm_en", 64'(strm_en), 64'd0);
        chk("R1 mtx_en", 64'(mtx_en), 64'd0);
        chk("R1 vreg_clr", 64'(vreg_clr), 64'd0);
        chk("R1 preg_clr", 64'(preg_clr), 64'd0);
        chk("R1 mtx_clr", 64'(mtx_clr), 64'd0);
        chk("R1 q_rvalid", 64'(q_rvalid), 64'd0);

        for (int s0 = 0; s0 < 2; s0++)
        for (int m0 = 0; m0 < 2; m0++)
        for (int v = 0; v < 2; v++)
        for (int op = 0; op < 8; op++)
        for (int ss = 0; ss < 2; ss++)
        for (int sm = 0; sm < 2; sm++)
        for (int wd = 0; wd < 2; wd++) begin
            issue(1'b1, 3'd1, 1'b0, 1'b0, 1'(s0));
            issue(1'b1, 3'd2, 1'b0, 1'b0, 1'(m0));
            tick();
            es = 1'(s0); em = 1'(m0);
            if (v == 1) begin
                case (op)
                    1: begin es = 1'(wd); t = "R2"; end
                    2: begin em = 1'(wd); t = "R3"; end
                    3: begin if (ss == 1) es = 1'b1; if (sm == 1) em = 1'b1; t = "R4"; end
                    4: begin if (ss == 1) es = 1'b0; if (sm == 1) em = 1'b0; t = "R4"; end
                    default: t = "R11";
                endcase
            end else t = "R11";
            issue(1'(v), 3'(op), 1'(ss), 1'(sm), 1'(wd));
            chk({t, " strm_en"}, 64'(strm_en), 64'(es));
            chk({t, " mtx_en"}, 64'(mtx_en), 64'(em));
            if (es != 1'(s0)) begin
                chk("R5 vreg_clr", 64'(vreg_clr), 64'd1);
                chk("R5 preg_clr", 64'(preg_clr), 64'd1);
            end else begin
                chk("R6 vreg_clr", 64'(vreg_clr), 64'd0);
                chk("R6 preg_clr", 64'(preg_clr), 64'd0);
            end
            chk("R7 mtx_clr", 64'(mtx_clr), 64'(em & ~1'(m0)));
            tick();
            chk("R5 vreg_clr width", 64'(vreg_clr), 64'd0);
            chk("R7 mtx_clr width", 64'(mtx_clr), 64'd0);
            chk("R11 hold strm_en", 64'(strm_en), 64'(es));
        end

        for (int s = 0; s < 2; s++) begin
            issue(1'b1, 3'd1, 1'b0, 1'b0, 1'(s));
            for (int code = 0; code < 8; code++)
            for (int imm = -32; imm < 32; imm++) begin
                longint eb;
                eb = 64'd16 << ((code > 4) ? 4 : code);
                len_ctl = 3'(code);
                q_imm = 6'(imm);
                q_valid = 1'b1;
                #1;
                chk((code > 4) ? "R9 svl_bytes" : "R8 svl_bytes", 64'(svl_bytes), 64'(eb));
                tick();
                q_valid = 1'b0;
                chk("R10 q_rvalid", 64'(q_rvalid), 64'd1);
                chk("R10 q_result", q_result, 64'(eb * longint'(imm)));
            end
            tick();
            chk("R10 q_rvalid idle", 64'(q_rvalid), 64'd0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule